// File: doc/BRIEF.md
# Dual-Channel IDE Card Register Interface

This block is the card-side register logic for an expansion card that carries two parallel ATA channels behind a single host byte window. It decodes synchronous host byte reads and writes. Taskfile and device-control accesses become per-channel chip-selects with a register index. The block also holds a small select register, a read-only 4-bit card identity code, and, for each channel, an interrupt mask and a pending latch. The two channels' interrupts are combined into one card interrupt line.

Host software first writes the select register with the window bit set. After that, the taskfile, control and interrupt locations of both channels respond. A write to a channel's interrupt-enable location opens that channel's mask, and a read of the same location closes it. The status location reports whether the drive is signalling. Bit 0 of the select register is brought out to steer an external DMA engine to one channel. ATA bus timing and the DMA engine itself lie outside this block.

Top module: `ide_dual_regif`

## Requirements
- R1: After reset the select register is 0x00, both masks are closed, no interrupt is pending, and `card_irq`, `dma_chan`, `tf_cs` and `host_rdata` are all 0.
- R2: A read at 0x2280 + 4*k (k = 0..3) returns bit k of the card identity (default 3) in data bit 0, with the other bits 0. This works whether the window is open or closed.
- R3: The select register at address 0x0000 is a read/write byte. Its bit 0 drives `dma_chan` (0 = channel 0, 1 = channel 1), and its bit 5 opens the window.
- R4: With the window open, an access at channel base (0x2000 for channel 0, 0x3000 for channel 1) plus n*64, for n = 0..7, asserts only that channel's `tf_cs` bit in the same cycle, with `tf_idx` = n, `tf_ctl` = 0 and `tf_we` = `host_we`. A read returns that channel's taskfile data on `host_rdata` one cycle later.
- R5: With the window open, an access at channel base + 0x380 asserts that channel's `tf_cs` with `tf_ctl` = 1 and `tf_idx` = 0.
- R6: With the window closed, reads of taskfile, control, interrupt-enable and status locations return 0xFF. These accesses assert no `tf_cs`, and they leave both masks unchanged.
- R7: With the window open, a write of any value to channel base + 0x200 opens that channel's mask. A read of that location closes the mask and returns 0x00.
- R8: With the window open, a read at channel base + 0x290 returns the channel's pending latch in bit 0, with the other bits 0.
- R9: A channel's pending latch sets on the first clock edge that sees its drive interrupt input rise. It stays set while the input is held high and clears on the first edge that sees the input low.
- R10: `card_irq` is 1 exactly when some channel had both its pending latch and its mask set at the previous clock edge.
- R11: Any other address reads 0x00 and asserts no chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after a read |
| drv_irq | input | 2 | Drive interrupt inputs, bit c for channel c |
| card_irq | output | 1 | Combined registered card interrupt |
| dma_chan | output | 1 | DMA routing selection |
| tf_cs | output | 2 | Per-channel taskfile chip-select |
| tf_ctl | output | 1 | Access targets the device-control register |
| tf_idx | output | 3 | Taskfile register index |
| tf_we | output | 1 | Taskfile write strobe |
| tf_wdata | output | 8 | Taskfile write data |
| tf_rdata0 | input | 8 | Channel 0 taskfile read data |
| tf_rdata1 | input | 8 | Channel 1 taskfile read data |

## Verification
The assertions assume that the drive interrupt inputs are already synchronous to `clk`. They also assume that `host_cs` is a single-cycle strobe, so an arm and a disarm of one mask never coincide. The bench changes every input only on the falling clock edge, and it holds the drive inputs low during reset so that a rising edge is never hidden by reset. The address sweeps cover all 16384 addresses with the window closed and with it open. The interrupt sequences work through a single channel at a time.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int NCH  = 2;
  localparam int CH_W = 1;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    RG_NONE, RG_SEL, RG_ID, RG_TF, RG_CTL, RG_IEN, RG_STAT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [CH_W-1:0]  ch;
    logic [IDX_W-1:0] idx;
    logic [1:0]       idbit;
  } dec_t;
endpackage

// File: rtl/idec_addr_dec.sv
module idec_addr_dec
  import idec_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int OFF_W     = 12,
  parameter int CH_BASE   = 'h2000,
  parameter int TF_SHIFT  = 6,
  parameter int CTL_OFS   = 'h380,
  parameter int IEN_OFS   = 'h200,
  parameter int STAT_OFS  = 'h290,
  parameter int ID_OFS    = 'h280,
  parameter int SEL_ADDR  = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int HI_W    = ADDR_W - OFF_W;
  localparam int BASE_HI = CH_BASE >> OFF_W;
  localparam int TF_SPAN = (1 << IDX_W) << TF_SHIFT;

  logic [OFF_W-1:0] off;
  assign off = addr[OFF_W-1:0];

  always_comb begin
    dec = '0;
    dec.kind = RG_NONE;
    if (addr == ADDR_W'(SEL_ADDR)) begin
      dec.kind = RG_SEL;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (addr[ADDR_W-1:OFF_W] == HI_W'(BASE_HI + c)) begin
          dec.ch = CH_W'(c);
          if (off < OFF_W'(TF_SPAN) && off[TF_SHIFT-1:0] == '0) begin
            dec.kind = RG_TF;
            dec.idx  = off[TF_SHIFT +: IDX_W];
          end else if (off == OFF_W'(CTL_OFS)) begin
            dec.kind = RG_CTL;
          end else if (off == OFF_W'(IEN_OFS)) begin
            dec.kind = RG_IEN;
          end else if (off == OFF_W'(STAT_OFS)) begin
            dec.kind = RG_STAT;
          end else if (c == 0 && (off >> 4) == OFF_W'(ID_OFS >> 4) && off[1:0] == 2'b00) begin
            dec.kind  = RG_ID;
            dec.idbit = off[3:2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/idec_chan_irq.sv
module idec_chan_irq (
  input  logic clk,
  input  logic rst,
  input  logic drv_irq,
  input  logic arm,
  input  logic disarm,
  output logic pending,
  output logic mask_open
);
  logic drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q     <= 1'b0;
      pending   <= 1'b0;
      mask_open <= 1'b0;
    end else begin
      drv_q <= drv_irq;
      if (!drv_irq)     pending <= 1'b0;
      else if (!drv_q)  pending <= 1'b1;
      if (arm)          mask_open <= 1'b1;
      else if (disarm)  mask_open <= 1'b0;
    end
  end

  // R7: a write arms the mask, a read disarms it
  a_r7_arm_opens: assert property (@(posedge clk) disable iff (rst)
    arm |=> mask_open);
  a_r7_disarm_closes: assert property (@(posedge clk) disable iff (rst)
    (disarm && !arm) |=> !mask_open);
  // R9: latch follows rising edge and a low input
  a_r9_low_clears: assert property (@(posedge clk) disable iff (rst)
    !drv_irq |=> !pending);
  a_r9_rise_sets: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_irq) |=> pending);
endmodule

// File: rtl/ide_dual_regif.sv
module ide_dual_regif
  import idec_pkg::*;
#(
  parameter int         ADDR_W  = 14,
  parameter int         DATA_W  = 8,
  parameter int         WIN_BIT = 5,
  parameter int         DMA_BIT = 0,
  parameter logic [3:0] CARD_ID = 4'd3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [NCH-1:0]    drv_irq,
  output logic              card_irq,
  output logic              dma_chan,
  output logic [NCH-1:0]    tf_cs,
  output logic              tf_ctl,
  output logic [IDX_W-1:0]  tf_idx,
  output logic              tf_we,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata0,
  input  logic [DATA_W-1:0] tf_rdata1
);
  localparam logic [DATA_W-1:0] CLOSED_VAL = '1;

  dec_t              dec;
  logic [DATA_W-1:0] sel_q;
  logic              win_open, rd, wr, tf_hit;
  logic [NCH-1:0]    arm, disarm, pend, mask;
  logic [DATA_W-1:0] rd_mux;

  idec_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (host_addr),
    .dec  (dec)
  );

  assign win_open = sel_q[WIN_BIT];
  assign rd       = host_cs && !host_we;
  assign wr       = host_cs && host_we;
  assign tf_hit   = host_cs && win_open && (dec.kind == RG_TF || dec.kind == RG_CTL);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign tf_cs[c]  = tf_hit && (dec.ch == CH_W'(c));
      assign arm[c]    = wr && win_open && dec.kind == RG_IEN && dec.ch == CH_W'(c);
      assign disarm[c] = rd && win_open && dec.kind == RG_IEN && dec.ch == CH_W'(c);
      idec_chan_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .drv_irq   (drv_irq[c]),
        .arm       (arm[c]),
        .disarm    (disarm[c]),
        .pending   (pend[c]),
        .mask_open (mask[c])
      );
    end
  endgenerate

  assign tf_ctl   = tf_hit && dec.kind == RG_CTL;
  assign tf_idx   = tf_hit ? dec.idx : '0;
  assign tf_we    = tf_hit && host_we;
  assign tf_wdata = host_wdata;
  assign dma_chan = sel_q[DMA_BIT];

  always_comb begin
    rd_mux = '0;
    unique case (dec.kind)
      RG_SEL:        rd_mux = sel_q;
      RG_ID:         rd_mux = DATA_W'(CARD_ID[dec.idbit]);
      RG_TF, RG_CTL: rd_mux = !win_open ? CLOSED_VAL : (dec.ch != '0 ? tf_rdata1 : tf_rdata0);
      RG_IEN:        rd_mux = win_open ? '0 : CLOSED_VAL;
      RG_STAT:       rd_mux = win_open ? DATA_W'(pend[dec.ch]) : CLOSED_VAL;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      host_rdata <= '0;
      card_irq   <= 1'b0;
    end else begin
      if (wr && dec.kind == RG_SEL) sel_q <= host_wdata;
      if (rd) host_rdata <= rd_mux;
      card_irq <= |(pend & mask);
    end
  end

  // R6: a closed window produces no chip-select
  a_r6_closed_no_cs: assert property (@(posedge clk) disable iff (rst)
    !win_open |-> tf_cs == '0);
  // R6: a closed window never moves a mask
  a_r6_closed_mask_stable: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(mask));
  // R4: at most one channel selected
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tf_cs));
  // R10: all masks closed means no interrupt next cycle
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !card_irq);
endmodule

// File: tb/tb_ide_dual_regif.sv
`timescale 1ns/100ps
module tb_ide_dual_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 1'b0, host_we = 1'b0;
  logic [13:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [1:0]  drv_irq = '0;
  logic        card_irq, dma_chan, tf_ctl, tf_we;
  logic [1:0]  tf_cs;
  logic [2:0]  tf_idx;
  logic [7:0]  tf_wdata;
  logic [7:0]  tf_rdata0 = 8'hA5, tf_rdata1 = 8'h3C;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ide_dual_regif dut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .drv_irq(drv_irq), .card_irq(card_irq), .dma_chan(dma_chan),
    .tf_cs(tf_cs), .tf_ctl(tf_ctl), .tf_idx(tf_idx), .tf_we(tf_we),
    .tf_wdata(tf_wdata), .tf_rdata0(tf_rdata0), .tf_rdata1(tf_rdata1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [13:0] a, input logic [7:0] d,
                     output logic [7:0] rdv, output logic [1:0] cs, output logic ctl,
                     output logic [2:0] idx, output logic twe);
    @(negedge clk);
    host_cs = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #1;
    cs = tf_cs; ctl = tf_ctl; idx = tf_idx; twe = tf_we;
    @(negedge clk);
    rdv = host_rdata;
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd8(input logic [13:0] a, output logic [7:0] v);
    logic [1:0] c; logic t, w; logic [2:0] i;
    acc(1'b0, a, 8'h00, v, c, t, i, w);
  endtask

  task automatic wr8(input logic [13:0] a, input logic [7:0] d);
    logic [7:0] v; logic [1:0] c; logic t, w; logic [2:0] i;
    acc(1'b1, a, d, v, c, t, i, w);
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // kind: 0 none, 1 select, 2 identity, 3 taskfile, 4 control, 5 irq enable, 6 status
  task automatic classify(input int a, output int kind, output int ch, output int idx, output int ib);
    int region, off;
    kind = 0; ch = 0; idx = 0; ib = 0;
    region = a / 4096; off = a % 4096;
    if (a == 0) kind = 1;
    else if (region == 2 || region == 3) begin
      ch = region - 2;
      if (off < 512 && off % 64 == 0) begin kind = 3; idx = off / 64; end
      else if (off == 'h380) kind = 4;
      else if (off == 'h200) kind = 5;
      else if (off == 'h290) kind = 6;
      else if (ch == 0 && off >= 'h280 && off <= 'h28C && off % 4 == 0) begin
        kind = 2; ib = (off - 'h280) / 4;
      end
    end
  endtask

  function automatic string tag_of(int kind, bit open);
    if (!open && kind >= 3) return "R6";
    case (kind)
      1: return "R3";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R7";
      6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic read_sweep(input bit open, input logic [7:0] selv);
    for (int a = 0; a < 16384; a++) begin
      int kind, ch, idx, ib;
      logic [7:0] rdv, erd; logic [1:0] cs, ecs; logic ctl, ectl, twe; logic [2:0] ix, eix;
      classify(a, kind, ch, idx, ib);
      acc(1'b0, 14'(a), 8'h00, rdv, cs, ctl, ix, twe);
      ecs = 2'b00; ectl = 1'b0; eix = 3'd0; erd = 8'h00;
      case (kind)
        1: erd = selv;
        2: erd = {7'd0, (4'd3 >> ib) & 4'd1 ? 1'b1 : 1'b0};
        3, 4: if (open) begin
                ecs = 2'b01 << ch; ectl = (kind == 4); eix = 3'(idx);
                erd = ch ? 8'h3C : 8'hA5;
              end else erd = 8'hFF;
        5, 6: erd = open ? 8'h00 : 8'hFF;
        default: erd = 8'h00;
      endcase
      chk(tag_of(kind, open), {18'd0, rdv, cs, ctl, ix, twe},
          {18'd0, erd, ecs, ectl, eix, 1'b0});
    end
  endtask

  initial begin
    logic [7:0] v;
    cyc(3);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 rdata", {24'd0, host_rdata}, 32'h0);
    chk("R1 irq/dma/cs", {28'd0, card_irq, dma_chan, tf_cs}, 32'h0);
    rd8(14'h0000, v); chk("R1 select reset", {24'd0, v}, 32'h0);

    // closed-window sweep: R2 identity, R6 gating, R11 unmapped
    read_sweep(1'b0, 8'h00);
    wr8(14'h2200, 8'h5A);  // R6 ignored enable write
    drv_irq[0] = 1'b1; cyc(3);
    chk("R6 closed enable write ignored", {31'd0, card_irq}, 32'h0);
    drv_irq[0] = 1'b0; cyc(2);

    // R3 select register
    wr8(14'h0000, 8'h21); #1;
    chk("R3 dma_chan one", {31'd0, dma_chan}, 32'h1);
    rd8(14'h0000, v); chk("R3 readback", {24'd0, v}, 32'h21);
    wr8(14'h0000, 8'h20); #1;
    chk("R3 dma_chan zero", {31'd0, dma_chan}, 32'h0);

    // open-window read sweep: R4 R5 R7 R8 R11
    read_sweep(1'b1, 8'h20);

    // open-window write sweep: R4 R5 chip-select and strobe
    for (int a = 1; a < 16384; a++) begin
      int kind, ch, idx, ib;
      logic [7:0] rdv; logic [1:0] cs, ecs; logic ctl, twe; logic [2:0] ix;
      classify(a, kind, ch, idx, ib);
      acc(1'b1, 14'(a), 8'(a), rdv, cs, ctl, ix, twe);
      ecs = (kind == 3 || kind == 4) ? (2'b01 << ch) : 2'b00;
      chk(tag_of(kind, 1'b1), {25'd0, cs, ctl, ix, twe},
          {25'd0, ecs, kind == 4, kind == 3 ? 3'(idx) : 3'd0, ecs != 2'b00});
    end
    rd8(14'h0000, v); chk("R3 select kept after sweep", {24'd0, v}, 32'h20);

    // interrupt sequences
    rst = 1'b1; cyc(2); rst = 1'b0;
    wr8(14'h0000, 8'h20);
    drv_irq[0] = 1'b1; cyc(1);
    rd8(14'h2290, v); chk("R8 R9 pending set", {24'd0, v}, 32'h1);
    rd8(14'h3290, v); chk("R8 other channel idle", {24'd0, v}, 32'h0);
    chk("R10 masked no irq", {31'd0, card_irq}, 32'h0);
    wr8(14'h2200, 8'h00); cyc(1);
    chk("R7 R10 armed irq", {31'd0, card_irq}, 32'h1);
    cyc(4);
    chk("R9 level hold", {31'd0, card_irq}, 32'h1);
    drv_irq[0] = 1'b0; cyc(2);
    chk("R9 R10 clear on low", {31'd0, card_irq}, 32'h0);
    rd8(14'h2290, v); chk("R9 status cleared", {24'd0, v}, 32'h0);
    drv_irq[0] = 1'b1; cyc(2);
    chk("R9 new rise", {31'd0, card_irq}, 32'h1);
    rd8(14'h2200, v); chk("R7 enable read value", {24'd0, v}, 32'h0);
    cyc(1);
    chk("R7 read masks", {31'd0, card_irq}, 32'h0);
    drv_irq[0] = 1'b0;
    drv_irq[1] = 1'b1; cyc(2);
    chk("R10 ch1 masked", {31'd0, card_irq}, 32'h0);
    wr8(14'h3200, 8'hFF); cyc(1);
    chk("R7 R10 ch1 armed", {31'd0, card_irq}, 32'h1);
    wr8(14'h0000, 8'h00);
    rd8(14'h3200, v); chk("R6 closed enable read", {24'd0, v}, 32'hFF);
    cyc(1);
    chk("R6 mask kept", {31'd0, card_irq}, 32'h1);
    drv_irq[1] = 1'b0; cyc(2);
    chk("R10 ch1 quiet", {31'd0, card_irq}, 32'h0);
    wr8(14'h2200, 8'h01);
    drv_irq[0] = 1'b1; cyc(3);
    chk("R6 closed arm ignored", {31'd0, card_irq}, 32'h0);
    drv_irq[1] = 1'b1; cyc(2);
    chk("R6 ch1 mask survived", {31'd0, card_irq}, 32'h1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule